// File: doc/BRIEF.md
# LED Channel Enable and ADC Source Sequencer

This block holds the control register of a two-channel LED driver and turns it into per-channel drive signals. A channel runs only while its external PWM pin and its register enable bit are both high. Setting a channel's enable bit also switches on that channel's switch-node pull-down, so no current leaks into the load while the channel is off. A digital override input stands in for an analog bypass level. While it is high, the stored channel enables are disregarded and both channels count as enabled, so each one follows only its PWM pin.

The same register selects which of three analog sources share one ADC: the thermal sensor, output voltage 1 and output voltage 2. A round-robin sequencer drives the ADC input multiplexer and a one-cycle conversion-start strobe. It waits for the ADC's conversion-done pulse and then moves on to the next enabled source, so the conversion rate is divided only among the sources that are enabled. With one source enabled, that source is converted back to back. With all three enabled, each is converted once in every three conversions.

Top module: `led_ctl_seq`

## Requirements
- R1: While `rst` is high and right after it, `rd_data` reads 0, `run_en` and `pulldown_en` are 0, `adc_start` is 0 and `adc_sel` is 0.
- R2: A write with `wr_en` high and `wr_addr` equal to `CTRL_ADDR` stores `wr_data` bits 4..0 at the next clock edge. Bits 8..5 always read 0. A write to any other address changes nothing. `rd_data` shows the register when `rd_addr` equals `CTRL_ADDR` and shows 0 for any other address. The read path is combinational.
- R3: With `bypass_in` low, `run_en[i]` equals `pwm_in[i]` AND register bit i. Bit 0 controls channel 1 and bit 1 controls channel 2. There is no clock delay from `pwm_in` to `run_en`.
- R4: With `bypass_in` low, `pulldown_en[i]` equals register bit i.
- R5: With `bypass_in` high, `run_en` equals `pwm_in` and `pulldown_en` is 2'b11. The stored register value is unchanged and still reads back through `rd_data`.
- R6: Source codes on `adc_sel` are 0 for thermal (enabled by bit 4), 1 for output 1 (bit 2) and 2 for output 2 (bit 3). Each new conversion selects the first enabled source in the cyclic order 0, 1, 2, starting from the one after the previous selection; the first conversion after reset starts the search at 0. Disabled sources are skipped with no idle slot.
- R7: `adc_start` is high for exactly one cycle, in the same cycle that `adc_sel` takes the new source. `adc_sel` changes only in a start cycle. A start comes one cycle after a decision point. A decision point is any idle cycle, or a converting cycle in which `adc_done` is high and `adc_start` is low. The enables in force in the decision cycle determine both whether a start follows and which source it selects.
- R8: While no sample-enable bit is set, no `adc_start` is issued and `adc_sel` keeps its last value.
- R9: No new conversion starts while one is outstanding. A change of the enables during a conversion takes effect only at the next decision point. An `adc_done` pulse that arrives while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 9 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 9 | Read data, combinational |
| pwm_in | input | 2 | External PWM pins, bit 0 = channel 1 |
| bypass_in | input | 1 | Override: treat both channel enables as set |
| adc_done | input | 1 | Conversion-done pulse from the ADC |
| run_en | output | 2 | Per-channel run enable |
| pulldown_en | output | 2 | Per-channel switch-node pull-down enable |
| adc_sel | output | 2 | ADC input multiplexer select |
| adc_start | output | 1 | One-cycle conversion-start strobe |

## Verification
A wrong stored enable shows up on `run_en`, `pulldown_en` and `rd_data` in the first cycle after the write edge. A wrong pointer in the sequencer shows up at the very next `adc_start`, as an unexpected `adc_sel` code or a source that is not enabled. A wrong converting/idle state shows up as a start issued one cycle early or late, or as a start overlapping a conversion. Because the bench predicts every start cycle and every selected code from the enables it wrote, each of these faults is caught at the first conversion boundary after it appears.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;

    localparam int REG_W     = 9;
    localparam int USED_W    = 5;
    localparam int NUM_CH    = 2;
    localparam int NUM_SRC   = 3;
    localparam int SEL_W     = $clog2(NUM_SRC);
    localparam logic [REG_W-1:0] USED_MASK = REG_W'((1 << USED_W) - 1);

    localparam logic [SEL_W-1:0] SRC_THERM = SEL_W'(0);
    localparam logic [SEL_W-1:0] SRC_VOUT1 = SEL_W'(1);
    localparam logic [SEL_W-1:0] SRC_VOUT2 = SEL_W'(2);

    // Field layout matches the bit positions seen by software.
    typedef struct packed {
        logic              therm_smp;   // bit 4
        logic              vout2_smp;   // bit 3
        logic              vout1_smp;   // bit 2
        logic [NUM_CH-1:0] ch_en;       // bits 1..0
    } ctrl_t;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_CONV = 1'b1
    } seq_st_e;

    function automatic logic [SEL_W-1:0] next_src(input logic [SEL_W-1:0] s);
        if (int'(s) >= NUM_SRC - 1)
            return '0;
        return s + 1'b1;
    endfunction

    // First enabled source at or after origin, cyclic.
    function automatic logic [SEL_W-1:0] pick_src(input logic [NUM_SRC-1:0] mask,
                                                  input logic [SEL_W-1:0]   origin);
        logic [SEL_W-1:0] res;
        logic             found;
        res   = origin;
        found = 1'b0;
        for (int k = 0; k < NUM_SRC; k++) begin
            int idx;
            idx = (int'(origin) + k) % NUM_SRC;
            if (mask[idx] && !found) begin
                res   = SEL_W'(idx);
                found = 1'b1;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/led_ctl_regfile.sv
module led_ctl_regfile
    import led_seq_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output ctrl_t             ctrl_o
);

    logic [REG_W-1:0] reg_q;
    logic             wr_hit;
    logic             rd_hit;

    assign wr_hit = wr_en && (wr_addr == CTRL_ADDR);
    assign rd_hit = (rd_addr == CTRL_ADDR);

    // Reserved bits are masked on the way in so they always hold zero.
    always_ff @(posedge clk) begin
        if (rst)
            reg_q <= '0;
        else if (wr_hit)
            reg_q <= wr_data & USED_MASK;
    end

    assign rd_data = rd_hit ? reg_q : '0;
    assign ctrl_o  = ctrl_t'(reg_q[USED_W-1:0]);

endmodule

// File: rtl/led_chan_gate.sv
module led_chan_gate
    import led_seq_pkg::*;
(
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] pwm_in,
    input  logic              bypass_in,
    output logic [NUM_CH-1:0] run_en,
    output logic [NUM_CH-1:0] pulldown_en
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic eff_en;
        assign eff_en         = bypass_in | ch_en[g];
        assign run_en[g]      = pwm_in[g] & eff_en;
        assign pulldown_en[g] = eff_en;
    end

endmodule

// File: rtl/adc_rr_seq.sv
module adc_rr_seq
    import led_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] smp_mask,
    input  logic               adc_done,
    output logic [SEL_W-1:0]   adc_sel,
    output logic               adc_start
);

    seq_st_e          state_q;
    logic [SEL_W-1:0] sel_q;
    logic             start_q;
    logic             first_q;
    logic             boundary;
    logic             any_en;
    logic [SEL_W-1:0] origin;
    logic [SEL_W-1:0] cand;

    // A done pulse in the start cycle itself is not taken as completion.
    assign boundary = (state_q == SQ_IDLE) || (adc_done && !start_q);
    assign any_en   = |smp_mask;

    always_comb begin
        origin = first_q ? SRC_THERM : next_src(sel_q);
        cand   = pick_src(smp_mask, origin);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            sel_q   <= SRC_THERM;
            start_q <= 1'b0;
            first_q <= 1'b1;
        end else begin
            start_q <= 1'b0;
            if (boundary) begin
                if (any_en) begin
                    sel_q   <= cand;
                    start_q <= 1'b1;
                    state_q <= SQ_CONV;
                    first_q <= 1'b0;
                end else begin
                    state_q <= SQ_IDLE;
                end
            end
        end
    end

    assign adc_sel   = sel_q;
    assign adc_start = start_q;

endmodule

// File: rtl/led_ctl_seq.sv
module led_ctl_seq
    import led_seq_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [8:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [8:0]        rd_data,
    input  logic [1:0]        pwm_in,
    input  logic              bypass_in,
    input  logic              adc_done,
    output logic [1:0]        run_en,
    output logic [1:0]        pulldown_en,
    output logic [1:0]        adc_sel,
    output logic              adc_start
);

    ctrl_t              ctrl_q;
    logic [NUM_SRC-1:0] smp_mask;

    led_ctl_regfile #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ctrl_o  (ctrl_q)
    );

    led_chan_gate u_gate (
        .ch_en       (ctrl_q.ch_en),
        .pwm_in      (pwm_in),
        .bypass_in   (bypass_in),
        .run_en      (run_en),
        .pulldown_en (pulldown_en)
    );

    // Mask index equals the source code on adc_sel.
    assign smp_mask = {ctrl_q.vout2_smp, ctrl_q.vout1_smp, ctrl_q.therm_smp};

    adc_rr_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .smp_mask  (smp_mask),
        .adc_done  (adc_done),
        .adc_sel   (adc_sel),
        .adc_start (adc_start)
    );

endmodule

// File: rtl/led_ctl_seq_chk.sv
module led_ctl_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] rsv_bits,
    input logic [4:0] ctrl_bits,
    input logic [1:0] pwm_in,
    input logic       bypass_in,
    input logic       adc_done,
    input logic [1:0] run_en,
    input logic [1:0] pulldown_en,
    input logic [1:0] adc_sel,
    input logic       adc_start
);

    logic [2:0] mask_now;
    logic [2:0] mask_prev;
    logic       busy_q;

    assign mask_now = {ctrl_bits[3], ctrl_bits[2], ctrl_bits[4]};

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_prev <= '0;
            busy_q    <= 1'b0;
        end else begin
            mask_prev <= mask_now;
            if (adc_start)
                busy_q <= 1'b1;
            else if (adc_done)
                busy_q <= 1'b0;
        end
    end

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsv_bits == 4'b0000);

    // R3
    gated_run_chk: assert property (@(posedge clk) disable iff (rst)
        !bypass_in |-> (run_en == (pwm_in & ctrl_bits[1:0])));

    // R4
    pulldown_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !bypass_in |-> (pulldown_en == ctrl_bits[1:0]));

    // R5
    bypass_force_chk: assert property (@(posedge clk) disable iff (rst)
        bypass_in |-> (run_en == pwm_in && pulldown_en == 2'b11));

    // R7
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);

    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adc_start |-> $stable(adc_sel));

    // R6
    start_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> (adc_sel < 2'd3 && mask_prev[adc_sel]));

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> !busy_q);

endmodule

bind led_ctl_seq led_ctl_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rsv_bits    (rd_data[8:5]),
    .ctrl_bits   (ctrl_q),
    .pwm_in      (pwm_in),
    .bypass_in   (bypass_in),
    .adc_done    (adc_done),
    .run_en      (run_en),
    .pulldown_en (pulldown_en),
    .adc_sel     (adc_sel),
    .adc_start   (adc_start)
);

// File: tb/led_ctl_seq_tb.sv
module led_ctl_seq_tb;

    localparam int         CLK_PERIOD = 10;
    localparam logic [3:0] CTRL_ADDR  = 4'd2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [8:0] wr_data = '0;
    logic [3:0] rd_addr = CTRL_ADDR;
    logic [8:0] rd_data;
    logic [1:0] pwm_in = 2'b11;
    logic       bypass_in = 1'b0;
    logic       adc_done = 1'b0;
    logic [1:0] run_en;
    logic [1:0] pulldown_en;
    logic [1:0] adc_sel;
    logic       adc_start;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // bench model state
    logic [8:0] reg_m = '0;
    logic [2:0] pm = '0;
    logic       pconv = 0, pstart = 0, pdone = 0, conv = 0;
    logic       first_m = 1;
    logic [1:0] sel_m = '0;
    int         adc_cnt = 0;
    int         lat = 4;
    logic       inj_done = 0;
    int         nstarts = 0;
    int         src_cnt [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    led_ctl_seq #(.ADDR_W(4), .CTRL_ADDR(CTRL_ADDR)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pwm_in(pwm_in), .bypass_in(bypass_in),
        .adc_done(adc_done), .run_en(run_en), .pulldown_en(pulldown_en),
        .adc_sel(adc_sel), .adc_start(adc_start)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // source mask: index 0 thermal=bit4, 1 vout1=bit2, 2 vout2=bit3
    function automatic logic [2:0] smask(input logic [8:0] r);
        return {r[3], r[2], r[4]};
    endfunction

    function automatic logic [1:0] bench_pick(input logic [2:0] m, input int origin);
        for (int k = 0; k < 3; k++) begin
            int i;
            i = (origin + k) % 3;
            if (m[i]) return 2'(i);
        end
        return 2'(origin);
    endfunction

    // monitor + ADC model, all at the falling edge
    always @(negedge clk) begin
        logic [1:0] eff;
        logic       exp_start;
        logic       nd;
        logic [1:0] exp_sel;
        if (rst) begin
            pm = '0; pconv = 0; pstart = 0; pdone = 0; conv = 0;
            first_m = 1; sel_m = '0; adc_cnt = 0; adc_done = 0;
        end else begin
            eff = bypass_in ? 2'b11 : reg_m[1:0];
            check(run_en == (pwm_in & eff), bypass_in ? "R5 run" : "R3 run",
                  run_en, pwm_in & eff);
            check(pulldown_en == eff, bypass_in ? "R5 pulldown" : "R4 pulldown",
                  pulldown_en, eff);
            check(rd_data == ((rd_addr == CTRL_ADDR) ? reg_m : 9'h000), "R2 read",
                  rd_data, (rd_addr == CTRL_ADDR) ? reg_m : 9'h000);
            exp_start = (pm != 0) && (!pconv || (pdone && !pstart));
            check(adc_start == exp_start, (pm == 0) ? "R8 start" : "R7/R9 start",
                  adc_start, exp_start);
            if (adc_start) begin
                exp_sel = bench_pick(pm, first_m ? 0 : (int'(sel_m) + 1) % 3);
                check(adc_sel == exp_sel, "R6 sel", adc_sel, exp_sel);
                sel_m = adc_sel;
                first_m = 0;
                nstarts++;
                if (adc_sel < 2'd3) src_cnt[adc_sel]++;
            end else begin
                check(adc_sel == sel_m, "R7 sel hold", adc_sel, sel_m);
            end
            if (adc_start) conv = 1;
            else if (pconv && pdone && !pstart) conv = 0;
            nd = 0;
            if (adc_cnt > 0) begin
                adc_cnt--;
                if (adc_cnt == 0) nd = 1;
            end
            if (adc_start) adc_cnt = lat;
            adc_done = nd | inj_done;
            pm = smask(reg_m); pconv = conv; pstart = adc_start; pdone = adc_done;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [8:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
        if (a == CTRL_ADDR) reg_m = d & 9'h01F;
        wr_en = 0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int s0, s1, s2, c0;
        int seed;
        seed = $urandom(32'h1A2B);
        for (int i = 0; i < 3; i++) src_cnt[i] = 0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(rd_data == 0, "R1 rd_data", rd_data, 0);
        check(run_en == 0, "R1 run_en", run_en, 0);
        check(pulldown_en == 0, "R1 pulldown_en", pulldown_en, 0);
        check(adc_start == 0 && adc_sel == 0, "R1 adc", {adc_start, adc_sel}, 0);
        tick();
        rst = 0;
        tick();
        @(negedge clk);
        check(rd_data == 0 && run_en == 0 && adc_start == 0, "R1 after reset",
              {rd_data, run_en, adc_start}, 0);

        // R2 reserved bits and foreign address
        wr(CTRL_ADDR, 9'h1E0);
        @(negedge clk);
        check(rd_data == 9'h000, "R2 reserved ignored", rd_data, 0);
        wr(CTRL_ADDR, 9'h003);
        wr(4'd5, 9'h1FF);
        @(negedge clk);
        check(rd_data == 9'h003, "R2 foreign write ignored", rd_data, 3);
        rd_addr = 4'd7; tick();
        @(negedge clk);
        check(rd_data == 9'h000, "R2 foreign read", rd_data, 0);
        rd_addr = CTRL_ADDR;

        // R3 / R4 pin patterns with channel 2 only
        wr(CTRL_ADDR, 9'h002);
        for (int p = 0; p < 4; p++) begin
            pwm_in = 2'(p); tick();
            @(negedge clk);
            check(run_en == (2'(p) & 2'b10), "R3 ch2 only", run_en, 2'(p) & 2'b10);
        end
        // R5 bypass with register cleared
        wr(CTRL_ADDR, 9'h000);
        bypass_in = 1; pwm_in = 2'b01; tick();
        @(negedge clk);
        check(run_en == 2'b01 && pulldown_en == 2'b11, "R5 bypass",
              {run_en, pulldown_en}, 4'b0111);
        check(rd_data == 9'h000, "R5 register kept", rd_data, 0);
        bypass_in = 0; pwm_in = 2'b11; tick();

        // R6 single source (output 2, bit 3) is converted back to back
        lat = 4;
        c0 = nstarts;
        wr(CTRL_ADDR, 9'h008);
        repeat (100) tick();
        check(nstarts - c0 >= 19 && nstarts - c0 <= 21, "R6 single-source rate",
              nstarts - c0, 20);
        // R6 all three share
        s0 = src_cnt[0]; s1 = src_cnt[1]; s2 = src_cnt[2];
        wr(CTRL_ADDR, 9'h01C);
        repeat (150) tick();
        s0 = src_cnt[0] - s0; s1 = src_cnt[1] - s1; s2 = src_cnt[2] - s2;
        check(s0 >= 9 && s1 >= 9 && s2 >= 9 && s0 - s1 <= 1 && s1 - s0 <= 1,
              "R6 three-way share", s0 * 256 + s1 * 16 + s2, 10 * 256 + 10 * 16 + 10);

        // R9 enable change during a conversion
        lat = 8;
        wr(CTRL_ADDR, 9'h010);
        while (!adc_start) tick();
        wr(CTRL_ADDR, 9'h004);
        repeat (30) tick();
        check(sel_m == 2'd1, "R9 change at boundary", sel_m, 1);

        // R8 nothing enabled, then R9 idle done ignored
        wr(CTRL_ADDR, 9'h000);
        repeat (20) tick();
        c0 = nstarts;
        repeat (30) tick();
        inj_done = 1; tick(); inj_done = 0;
        repeat (10) tick();
        check(nstarts == c0, "R8/R9 no start when idle", nstarts - c0, 0);

        // random phase
        for (int it = 0; it < 4000; it++) begin
            logic do_wr;
            do_wr   = ($urandom % 4) == 0;
            pwm_in  = 2'($urandom);
            bypass_in = ($urandom % 8) == 0;
            rd_addr = (($urandom % 4) == 0) ? 4'($urandom) : CTRL_ADDR;
            if (($urandom % 64) == 0) lat = 1 + ($urandom % 6);
            if (do_wr)
                wr((($urandom % 4) == 0) ? 4'($urandom) : CTRL_ADDR, 9'($urandom));
            else
                tick();
        end
        repeat (20) tick();
        summary();
        $finish;
    end

endmodule